// File: doc/BRIEF.md
# Interrupt Acceptance and Status Flag Update

This block sits beside the instruction sequencer of a small processor and decides, once per clock, whether an interrupt is taken. It sees three request sources. The first is a level-held maskable request that carries a 3-bit priority and a vector number. The second is a non-maskable request that is detected on its edge. The third is a one-cycle software-interrupt strobe that carries an interrupt number. The block owns the 16-bit status flag register and compares each request against the enable bit and the processor priority level held in that register.

When a request is taken, the block pulses an acknowledge for one cycle and presents the vector number. In the same clock edge it rewrites the enable bit, the stack-select bit and the processor priority level. Software can also load the flag register through a write port. When a write and an acceptance fall in the same cycle, the acceptance wins. Pushing state to the stack and fetching the vector are left to the sequencer.

Flag register layout: bit 0 carry, bit 1 debug, bit 2 zero, bit 3 sign, bit 4 bank select, bit 5 overflow, bit 6 interrupt enable (I), bit 7 stack select (U, 0 = interrupt stack), bits 14:12 processor priority level (IPL). Bits 11:8 and bit 15 are reserved.

Top module: `intr_gate`

## Requirements
- R1: After reset, `ack` is 0, `vec_num` is 0 and `flg_q` is 0, so I=0, U=0 and IPL=0.
- R2: When `flg_we` is 1 and no interrupt is accepted in that cycle, `flg_q` takes `flg_wdata` at the next edge. Reserved bits 11:8 and 15 always read 0, so writing 16'hFFFF reads back 16'h70FF.
- R3: A maskable request (`mreq`=1) is accepted only when I=1 and `mreq_lvl` is strictly greater than IPL. On acceptance `ack` is 1 in the cycle after the request is sampled and `vec_num` equals `mreq_vec`.
- R4: Accepting a maskable request clears I and U and loads IPL with the accepted `mreq_lvl`. Every other flag bit is kept.
- R5: A rising edge of `nmi_req` is accepted whatever the values of I and IPL. `vec_num` becomes the parameter `NMI_VEC` (default 8'hF8), I and U are cleared, and IPL is unchanged.
- R6: A `swi_stb` pulse is always accepted and `vec_num` equals `swi_num` zero-extended. I is cleared and IPL is unchanged. U is cleared when `swi_num` is 0 to 31 and keeps its value when `swi_num` is 32 to 63.
- R7: When sources coincide, a software strobe wins over a non-maskable edge, and a non-maskable edge wins over a maskable request. A non-maskable edge that loses is kept pending and is accepted in the next cycle.
- R8: `ack` lasts one cycle per acceptance. A maskable request held high is not accepted again until I=1 and its level exceeds IPL.
- R9: A flag write in the same cycle as an accepted interrupt is discarded. The flags take only the interrupt update.
- R10: `nmi_req` held high is accepted once. A further acceptance needs the input to go low and then rise again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq | input | 1 | Maskable request pending (level) |
| mreq_lvl | input | 3 | Priority of the maskable request |
| mreq_vec | input | 8 | Vector number of the maskable request |
| nmi_req | input | 1 | Non-maskable request (edge detected) |
| swi_stb | input | 1 | Software interrupt strobe, one cycle |
| swi_num | input | 6 | Software interrupt number |
| flg_we | input | 1 | Flag register write enable |
| flg_wdata | input | 16 | Flag register write data |
| ack | output | 1 | Acceptance pulse |
| vec_num | output | 8 | Vector number of the last accepted interrupt |
| flg_q | output | 16 | Flag register |
| flag_i | output | 1 | Interrupt enable bit |
| flag_u | output | 1 | Stack select bit |
| ipl | output | 3 | Processor priority level |

## Verification
The hardest case to reach from the ports is three sources meeting in a single cycle while the flags are set up in advance. In that cycle a held maskable level, a fresh non-maskable edge and a software strobe must be settled in strict order, and a non-maskable edge that loses must be carried over into the next cycle. The stimulus first loads the flag register through the write port. It then raises the sources together on one falling edge and checks `ack`, `vec_num` and `flg_q` on each of the next few cycles. The same method places a flag write in the very cycle a maskable request is accepted, which shows that the write is discarded.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
    localparam int LVL_W   = 3;
    localparam int VEC_W   = 8;
    localparam int SWN_W   = 6;
    localparam int FLG_W   = 16;
    // Software numbers below this limit switch to the interrupt stack.
    localparam int SW_ISTACK_LIM = 32;

    // Flag register bit positions
    localparam int B_I      = 6;
    localparam int B_U      = 7;
    localparam int B_IPL_LO = 12;
    localparam int B_IPL_HI = B_IPL_LO + LVL_W - 1;

    // Bits that hold state; every other bit reads as 0.
    localparam logic [FLG_W-1:0] FLG_WMASK = 16'h70FF;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_MASK = 2'd1,
        K_NMI  = 2'd2,
        K_SWI  = 2'd3
    } take_kind_e;
endpackage

// File: rtl/intr_gate_arb.sv
module intr_gate_arb
    import intr_gate_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'hF8
) (
    input  logic [FLG_W-1:0] flg,
    input  logic             mreq,
    input  logic [LVL_W-1:0] mreq_lvl,
    input  logic [VEC_W-1:0] mreq_vec,
    input  logic             nmi_hot,
    input  logic             swi_stb,
    input  logic [SWN_W-1:0] swi_num,
    output take_kind_e       kind,
    output logic [VEC_W-1:0] vec
);
    logic             mask_ok;
    logic [LVL_W-1:0] cur_ipl;

    always_comb begin
        cur_ipl = flg[B_IPL_HI:B_IPL_LO];
        mask_ok = mreq && flg[B_I] && (mreq_lvl > cur_ipl);
        kind    = K_NONE;
        vec     = '0;
        // Fixed order: software strobe, then non-maskable, then maskable
        if (swi_stb) begin
            kind = K_SWI;
            vec  = VEC_W'(swi_num);
        end else if (nmi_hot) begin
            kind = K_NMI;
            vec  = NMI_VEC;
        end else if (mask_ok) begin
            kind = K_MASK;
            vec  = mreq_vec;
        end
    end
endmodule

// File: rtl/intr_gate_flags.sv
module intr_gate_flags
    import intr_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  take_kind_e       kind,
    input  logic [LVL_W-1:0] mreq_lvl,
    input  logic [SWN_W-1:0] swi_num,
    input  logic             flg_we,
    input  logic [FLG_W-1:0] flg_wdata,
    output logic [FLG_W-1:0] flg_q
);
    logic [FLG_W-1:0] flg_d;

    always_comb begin
        flg_d = flg_q;
        if (kind != K_NONE) begin
            flg_d[B_I] = 1'b0;
            case (kind)
                K_MASK: begin
                    flg_d[B_U] = 1'b0;
                    flg_d[B_IPL_HI:B_IPL_LO] = mreq_lvl;
                end
                K_NMI: flg_d[B_U] = 1'b0;
                K_SWI: if (swi_num < SWN_W'(SW_ISTACK_LIM)) flg_d[B_U] = 1'b0;
                default: ;
            endcase
        end else if (flg_we) begin
            flg_d = flg_wdata & FLG_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    // R2: reserved positions never hold a 1
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q & ~FLG_WMASK) == '0);
endmodule

// File: rtl/intr_gate.sv
module intr_gate
    import intr_gate_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreq,
    input  logic [LVL_W-1:0] mreq_lvl,
    input  logic [VEC_W-1:0] mreq_vec,
    input  logic             nmi_req,
    input  logic             swi_stb,
    input  logic [SWN_W-1:0] swi_num,
    input  logic             flg_we,
    input  logic [FLG_W-1:0] flg_wdata,
    output logic             ack,
    output logic [VEC_W-1:0] vec_num,
    output logic [FLG_W-1:0] flg_q,
    output logic             flag_i,
    output logic             flag_u,
    output logic [LVL_W-1:0] ipl
);
    typedef struct packed {
        logic             ack;
        logic [VEC_W-1:0] vec;
        take_kind_e       kind;
        logic             nmi_prev;
        logic             nmi_pend;
    } st_t;

    st_t              st_d, st_q;
    take_kind_e       kind;
    logic [VEC_W-1:0] vec;
    logic             nmi_hot;

    assign nmi_hot = st_q.nmi_pend || (nmi_req && !st_q.nmi_prev);

    intr_gate_arb #(.NMI_VEC(NMI_VEC)) u_arb (
        .flg      (flg_q),
        .mreq     (mreq),
        .mreq_lvl (mreq_lvl),
        .mreq_vec (mreq_vec),
        .nmi_hot  (nmi_hot),
        .swi_stb  (swi_stb),
        .swi_num  (swi_num),
        .kind     (kind),
        .vec      (vec)
    );

    intr_gate_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .mreq_lvl  (mreq_lvl),
        .swi_num   (swi_num),
        .flg_we    (flg_we),
        .flg_wdata (flg_wdata),
        .flg_q     (flg_q)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack      = (kind != K_NONE);
        st_d.kind     = kind;
        st_d.nmi_prev = nmi_req;
        st_d.nmi_pend = nmi_hot && (kind != K_NMI);
        if (kind != K_NONE) st_d.vec = vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ack: 1'b0, vec: '0, kind: K_NONE,
                               nmi_prev: 1'b0, nmi_pend: 1'b0};
        else        st_q <= st_d;
    end

    assign ack     = st_q.ack;
    assign vec_num = st_q.vec;
    assign flag_i  = flg_q[B_I];
    assign flag_u  = flg_q[B_U];
    assign ipl     = flg_q[B_IPL_HI:B_IPL_LO];

    // R3: a taken maskable request outranked the level with I set
    a_r3_level_above: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == K_MASK) |->
            ($past(flag_i) && $past(mreq_lvl) > $past(ipl)));
    // R4: the level is loaded on maskable acceptance
    a_r4_ipl_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == K_MASK) |-> (ipl == $past(mreq_lvl) && !flag_u));
    // R5: non-maskable acceptance presents its fixed vector
    a_r5_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == K_NMI) |-> (vec_num == NMI_VEC && !flag_u));
    // R6: high software numbers keep the stack select
    a_r6_hi_swi_keeps_u: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == K_SWI && $past(swi_num) >= SWN_W'(SW_ISTACK_LIM))
            |-> (flag_u == $past(flag_u)));
    // R6: low software numbers select the interrupt stack
    a_r6_lo_swi_clears_u: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == K_SWI && $past(swi_num) < SWN_W'(SW_ISTACK_LIM))
            |-> !flag_u);
    // R8: every acceptance leaves interrupts disabled
    a_r8_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !flag_i);
    // R8: two maskable acceptances never come back to back
    a_r8_no_mask_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.kind == K_MASK) |=> !(ack && st_q.kind == K_MASK));
endmodule

// File: tb/sim_intr_gate.sv
module sim_intr_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreq = 1'b0;
    logic [2:0]  mreq_lvl = '0;
    logic [7:0]  mreq_vec = '0;
    logic        nmi_req = 1'b0;
    logic        swi_stb = 1'b0;
    logic [5:0]  swi_num = '0;
    logic        flg_we = 1'b0;
    logic [15:0] flg_wdata = '0;
    logic        ack;
    logic [7:0]  vec_num;
    logic [15:0] flg_q;
    logic        flag_i, flag_u;
    logic [2:0]  ipl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    intr_gate u0 (
        .clk(clk), .rst_n(rst_n), .mreq(mreq), .mreq_lvl(mreq_lvl),
        .mreq_vec(mreq_vec), .nmi_req(nmi_req), .swi_stb(swi_stb),
        .swi_num(swi_num), .flg_we(flg_we), .flg_wdata(flg_wdata),
        .ack(ack), .vec_num(vec_num), .flg_q(flg_q), .flag_i(flag_i),
        .flag_u(flag_u), .ipl(ipl)
    );

    typedef struct packed {
        logic [15:0] fin;
        logic        mq;
        logic [2:0]  lv;
        logic [7:0]  mv;
        logic        sw;
        logic [5:0]  sn;
        logic        eack;
        logic [7:0]  evec;
        logic [15:0] efl;
    } row_t;

    // flags: I=bit6 U=bit7 IPL=14:12
    localparam int NROW = 11;
    localparam row_t TBL [NROW] = '{
        '{16'h30C1, 1'b1, 3'd5, 8'h21, 1'b0, 6'd0,  1'b1, 8'h21, 16'h5001}, // R3 R4
        '{16'h50C0, 1'b1, 3'd5, 8'h22, 1'b0, 6'd0,  1'b0, 8'h00, 16'h50C0}, // R3 equal level
        '{16'h0080, 1'b1, 3'd7, 8'h23, 1'b0, 6'd0,  1'b0, 8'h00, 16'h0080}, // R3 I=0
        '{16'h60C4, 1'b1, 3'd7, 8'h3F, 1'b0, 6'd0,  1'b1, 8'h3F, 16'h7004}, // R4 top level
        '{16'h0040, 1'b1, 3'd1, 8'h10, 1'b0, 6'd0,  1'b1, 8'h10, 16'h1000}, // R3 lowest
        '{16'h2080, 1'b0, 3'd0, 8'h00, 1'b1, 6'd5,  1'b1, 8'h05, 16'h2000}, // R6 I=0
        '{16'h20C0, 1'b0, 3'd0, 8'h00, 1'b1, 6'd40, 1'b1, 8'h28, 16'h2080}, // R6 keep U
        '{16'h00C0, 1'b0, 3'd0, 8'h00, 1'b1, 6'd31, 1'b1, 8'h1F, 16'h0000}, // R6 edge 31
        '{16'h0040, 1'b0, 3'd0, 8'h00, 1'b1, 6'd32, 1'b1, 8'h20, 16'h0000}, // R6 edge 32
        '{16'h00C0, 1'b0, 3'd0, 8'h00, 1'b1, 6'd63, 1'b1, 8'h3F, 16'h0080}, // R6 max
        '{16'h00C0, 1'b1, 3'd7, 8'h44, 1'b1, 6'd9,  1'b1, 8'h09, 16'h0000}  // R7 swi beats mask
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_flags(input logic [15:0] v);
        flg_we = 1'b1; flg_wdata = v;
        step();
        flg_we = 1'b0; flg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ack", {15'd0, ack}, 16'd0);
        chk("R1 vec", {8'd0, vec_num}, 16'd0);
        chk("R1 flg", flg_q, 16'h0000);
        rst_n = 1'b1;
        step();

        // R2: write path, reserved bits read 0
        wr_flags(16'hFFFF);
        chk("R2 reserved", flg_q, 16'h70FF);
        wr_flags(16'h0000);

        for (int k = 0; k < NROW; k++) begin
            wr_flags(TBL[k].fin);
            mreq = TBL[k].mq; mreq_lvl = TBL[k].lv; mreq_vec = TBL[k].mv;
            swi_stb = TBL[k].sw; swi_num = TBL[k].sn;
            step();
            swi_stb = 1'b0;
            mreq = 1'b0;
            chk($sformatf("R3/R6 row%0d ack", k), {15'd0, ack}, {15'd0, TBL[k].eack});
            if (TBL[k].eack)
                chk($sformatf("R3/R6 row%0d vec", k), {8'd0, vec_num}, {8'd0, TBL[k].evec});
            chk($sformatf("R4/R6 row%0d flg", k), flg_q, TBL[k].efl);
            step();
            chk($sformatf("R8 row%0d pulse", k), {15'd0, ack}, 16'd0);
        end

        // R9: write in accepting cycle is dropped
        wr_flags(16'h0040);
        mreq = 1'b1; mreq_lvl = 3'd4; mreq_vec = 8'h55;
        flg_we = 1'b1; flg_wdata = 16'h0041;
        step();
        flg_we = 1'b0;
        chk("R9 ack", {15'd0, ack}, 16'd1);
        chk("R9 flg", flg_q, 16'h4000);
        // R8: held request not taken again
        step();
        chk("R8 held I=0", {15'd0, ack}, 16'd0);
        wr_flags(16'h4040);
        chk("R8 write while held", {15'd0, ack}, 16'd0);
        step();
        chk("R8 level not above", {15'd0, ack}, 16'd0);
        mreq_lvl = 3'd6; mreq_vec = 8'h66;
        step();
        chk("R8 retaken ack", {15'd0, ack}, 16'd1);
        chk("R8 retaken vec", {8'd0, vec_num}, 16'h0066);
        chk("R8 retaken flg", flg_q, 16'h6000);
        mreq = 1'b0;
        step();

        // R5, R10: edge NMI with interrupts disabled
        wr_flags(16'h3080);
        nmi_req = 1'b1;
        step();
        chk("R5 ack", {15'd0, ack}, 16'd1);
        chk("R5 vec", {8'd0, vec_num}, 16'h00F8);
        chk("R5 flg", flg_q, 16'h3000);
        step();
        chk("R10 held", {15'd0, ack}, 16'd0);
        step();
        chk("R10 held2", {15'd0, ack}, 16'd0);
        nmi_req = 1'b0;
        step();
        chk("R10 low", {15'd0, ack}, 16'd0);
        nmi_req = 1'b1;
        step();
        chk("R10 new edge", {15'd0, ack}, 16'd1);
        nmi_req = 1'b0;
        step();

        // R7: swi and NMI edge together, NMI deferred one cycle
        wr_flags(16'h00C0);
        nmi_req = 1'b1; swi_stb = 1'b1; swi_num = 6'd3;
        step();
        swi_stb = 1'b0;
        chk("R7 swi first ack", {15'd0, ack}, 16'd1);
        chk("R7 swi first vec", {8'd0, vec_num}, 16'h0003);
        step();
        chk("R7 nmi deferred ack", {15'd0, ack}, 16'd1);
        chk("R7 nmi deferred vec", {8'd0, vec_num}, 16'h00F8);
        step();
        chk("R7 nmi once", {15'd0, ack}, 16'd0);
        nmi_req = 1'b0;
        step();

        // R7: NMI beats maskable; maskable then blocked by I=0
        wr_flags(16'h00C0);
        nmi_req = 1'b1; mreq = 1'b1; mreq_lvl = 3'd7; mreq_vec = 8'h77;
        step();
        chk("R7 nmi over mask vec", {8'd0, vec_num}, 16'h00F8);
        chk("R7 nmi over mask flg", flg_q, 16'h0000);
        step();
        chk("R7 mask blocked", {15'd0, ack}, 16'd0);
        mreq = 1'b0; nmi_req = 1'b0;
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule